// File: doc/BRIEF.md
# Supply Undervoltage Lockout Monitor

This block watches two supply readings that an upstream converter delivers as unsigned millivolt codes. One reading is the low-side supply and the other is the floating high-side supply, and each arrives with its own valid strobe. For every supply the block keeps a lockout flag. While the flag is high, the gate-control logic downstream must keep that side's output off.

A flag is released as soon as one valid sample lies above the supply's turn-on level. It is set again only after a run of valid samples below the lower turn-off level. That run must last a parameterised number of sampled cycles, so a brief negative spike on a supply cannot trip the lockout. Samples between the two levels leave the flag as it is.

A parameter picks between two threshold sets. In the first set the low side has its own thresholds and they sit above those of the high side, which helps the bootstrap supply come up. In the second set both sides share one pair of levels.

Top module: `uvlo_monitor`

## Requirements
- R1: While reset is asserted, and after it is released until a qualifying rising sample arrives, both lockout flags read 1.
- R2: A valid sample strictly greater than a channel's turn-on threshold clears that channel's lockout flag. The flag reads 0 after the clock edge that captured the sample.
- R3: While a flag is clear, QUAL_CYCLES valid samples strictly below the channel's turn-off threshold with no valid in-band sample between them set the flag. The flag reads 1 after the edge that captures the last of those samples, and not before.
- R4: A valid sample at or between the two thresholds leaves the flag unchanged. When the flag is clear, such a sample also restarts the below-threshold count from zero.
- R5: A cycle whose valid strobe is low changes neither the flag nor the below-threshold count of that channel, whatever the millivolt code is.
- R6: With IGBT_MODE=1 the defaults are turn-on 12500 mV and turn-off 11600 mV on the low side, and turn-on 11600 mV and turn-off 10700 mV on the high side. As a result, 12000 mV releases the high side but not the low side.
- R7: With IGBT_MODE=0 both channels use turn-on 9100 mV and turn-off 8300 mV.
- R8: The two channels are independent: a sample on one channel never changes the other channel's flag or count.
- R9: A sample equal to a threshold is not a crossing. A value equal to the turn-on level does not release the flag, and a value equal to the turn-off level does not count toward lockout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lowMv | input | MV_W | Low-side supply reading in millivolts |
| lowValid | input | 1 | lowMv carries a new sample this cycle |
| highMv | input | MV_W | High-side supply reading in millivolts |
| highValid | input | 1 | highMv carries a new sample this cycle |
| lowLockout | output | 1 | Low-side supply in lockout |
| highLockout | output | 1 | High-side supply in lockout |

## Verification
Each flag is a single register fed by combinational compares. Every flag change therefore appears one edge after the sample that causes it, with no extra pipeline delay. The bench drives each sample on a falling edge and compares both flags on the next falling edge, one full rising edge later.

The bench covers the lockout entry sequence row by row. It checks the flag after each qualifying sample, so it shows that the flag stays clear for the first QUAL_CYCLES-1 samples and rises exactly with the last one. It also confirms that invalid cycles inserted inside the run neither advance nor restart the count.

// File: rtl/uvlo_pkg.sv
package uvlo_pkg;
  localparam int NUM_CH  = 2;
  localparam int CH_LOW  = 0;
  localparam int CH_HIGH = 1;

  // Per-channel compare results handed from datapath to control.
  typedef struct packed {
    logic valid;    // sample present this cycle
    logic riseHit;  // sample strictly above turn-on level
    logic fallHit;  // sample strictly below turn-off level
  } chanStrobe_t;
endpackage

// File: rtl/uvlo_compare.sv
module uvlo_compare
  import uvlo_pkg::*;
#(
  parameter int MV_W        = 16,
  parameter bit IGBT_MODE   = 1'b1,
  parameter int LS_RISE_MV  = 12500,
  parameter int LS_FALL_MV  = 11600,
  parameter int HS_RISE_MV  = 11600,
  parameter int HS_FALL_MV  = 10700,
  parameter int MOS_RISE_MV = 9100,
  parameter int MOS_FALL_MV = 8300
) (
  input  logic [NUM_CH-1:0][MV_W-1:0] sampleMv,
  input  logic [NUM_CH-1:0]           sampleValid,
  output chanStrobe_t [NUM_CH-1:0]    strobes
);
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : gCh
    localparam int RISE_INT = IGBT_MODE ? ((ch == CH_LOW) ? LS_RISE_MV : HS_RISE_MV)
                                        : MOS_RISE_MV;
    localparam int FALL_INT = IGBT_MODE ? ((ch == CH_LOW) ? LS_FALL_MV : HS_FALL_MV)
                                        : MOS_FALL_MV;
    localparam logic [MV_W-1:0] RISE_TH = MV_W'(RISE_INT);
    localparam logic [MV_W-1:0] FALL_TH = MV_W'(FALL_INT);

    always_comb begin
      strobes[ch].valid   = sampleValid[ch];
      strobes[ch].riseHit = sampleMv[ch] > RISE_TH;
      strobes[ch].fallHit = sampleMv[ch] < FALL_TH;
    end
  end
endmodule

// File: rtl/uvlo_ctrl.sv
module uvlo_ctrl
  import uvlo_pkg::*;
#(
  parameter int QUAL_CYCLES = 180
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  chanStrobe_t [NUM_CH-1:0] strobes,
  output logic [NUM_CH-1:0]        lockout
);
  localparam int CNT_W = $clog2(QUAL_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(QUAL_CYCLES - 1);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : gCh
    logic [CNT_W-1:0] dipCnt;
    logic             lockQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        lockQ  <= 1'b1;
        dipCnt <= '0;
      end else if (strobes[ch].valid) begin
        if (lockQ) begin
          dipCnt <= '0;
          if (strobes[ch].riseHit) lockQ <= 1'b0;
        end else if (strobes[ch].fallHit) begin
          if (dipCnt == CNT_LAST) begin
            lockQ  <= 1'b1;
            dipCnt <= '0;
          end else begin
            dipCnt <= dipCnt + 1'b1;
          end
        end else begin
          dipCnt <= '0;
        end
      end
    end

    assign lockout[ch] = lockQ;
  end
endmodule

// File: rtl/uvlo_monitor.sv
module uvlo_monitor
  import uvlo_pkg::*;
#(
  parameter int MV_W        = 16,
  parameter bit IGBT_MODE   = 1'b1,
  parameter int QUAL_CYCLES = 180,
  parameter int LS_RISE_MV  = 12500,
  parameter int LS_FALL_MV  = 11600,
  parameter int HS_RISE_MV  = 11600,
  parameter int HS_FALL_MV  = 10700,
  parameter int MOS_RISE_MV = 9100,
  parameter int MOS_FALL_MV = 8300
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [MV_W-1:0] lowMv,
  input  logic            lowValid,
  input  logic [MV_W-1:0] highMv,
  input  logic            highValid,
  output logic            lowLockout,
  output logic            highLockout
);
  logic [NUM_CH-1:0][MV_W-1:0] sampleMv;
  logic [NUM_CH-1:0]           sampleValid;
  chanStrobe_t [NUM_CH-1:0]    strobes;
  logic [NUM_CH-1:0]           lockout;

  assign sampleMv[CH_LOW]     = lowMv;
  assign sampleMv[CH_HIGH]    = highMv;
  assign sampleValid[CH_LOW]  = lowValid;
  assign sampleValid[CH_HIGH] = highValid;

  uvlo_compare #(
    .MV_W(MV_W), .IGBT_MODE(IGBT_MODE),
    .LS_RISE_MV(LS_RISE_MV), .LS_FALL_MV(LS_FALL_MV),
    .HS_RISE_MV(HS_RISE_MV), .HS_FALL_MV(HS_FALL_MV),
    .MOS_RISE_MV(MOS_RISE_MV), .MOS_FALL_MV(MOS_FALL_MV)
  ) u_compare (
    .sampleMv(sampleMv),
    .sampleValid(sampleValid),
    .strobes(strobes)
  );

  uvlo_ctrl #(.QUAL_CYCLES(QUAL_CYCLES)) u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .strobes(strobes),
    .lockout(lockout)
  );

  assign lowLockout  = lockout[CH_LOW];
  assign highLockout = lockout[CH_HIGH];
endmodule

// File: rtl/uvlo_monitor_chk.sv
module uvlo_monitor_chk
  import uvlo_pkg::*;
(
  input logic                     clk,
  input logic                     rstN,
  input chanStrobe_t [NUM_CH-1:0] strobes,
  input logic [NUM_CH-1:0]        lock
);
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : gChk
    AST_RELEASE_NEEDS_RISE: assert property (@(posedge clk) disable iff (!rstN)
      $fell(lock[ch]) |-> $past(strobes[ch].valid && strobes[ch].riseHit)); // R2
    AST_LOCK_NEEDS_DIP: assert property (@(posedge clk) disable iff (!rstN)
      $rose(lock[ch]) |-> $past(strobes[ch].valid && strobes[ch].fallHit)); // R3
    AST_BAND_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
      (strobes[ch].valid && !strobes[ch].riseHit && !strobes[ch].fallHit)
        |=> $stable(lock[ch])); // R4
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
      !strobes[ch].valid |=> $stable(lock[ch])); // R5
    AST_HITS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
      !(strobes[ch].riseHit && strobes[ch].fallHit)); // R9
  end
endmodule

bind uvlo_monitor uvlo_monitor_chk u_chk (
  .clk(clk),
  .rstN(rstN),
  .strobes(strobes),
  .lock(lockout)
);

// File: tb/uvlo_monitor_tb.sv
module uvlo_monitor_tb;
  localparam int QUAL = 4;
  localparam int MOS_QUAL = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] lowMv = '0, highMv = '0;
  logic lowValid = 1'b0, highValid = 1'b0;
  logic lowLockout, highLockout;
  logic [15:0] mLowMv = '0, mHighMv = '0;
  logic mLowValid = 1'b0, mHighValid = 1'b0;
  logic mLowLockout, mHighLockout;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  uvlo_monitor #(.QUAL_CYCLES(QUAL), .IGBT_MODE(1'b1)) u_dut (
    .clk(clk), .rstN(rstN),
    .lowMv(lowMv), .lowValid(lowValid),
    .highMv(highMv), .highValid(highValid),
    .lowLockout(lowLockout), .highLockout(highLockout)
  );

  uvlo_monitor #(.QUAL_CYCLES(MOS_QUAL), .IGBT_MODE(1'b0)) u_dutMos (
    .clk(clk), .rstN(rstN),
    .lowMv(mLowMv), .lowValid(mLowValid),
    .highMv(mHighMv), .highValid(mHighValid),
    .lowLockout(mLowLockout), .highLockout(mHighLockout)
  );

  typedef struct packed {
    logic [15:0] lo;
    logic        loV;
    logic [15:0] hi;
    logic        hiV;
    logic        expLo;
    logic        expHi;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{16'd12500, 1'b1, 16'd11600, 1'b1, 1'b1, 1'b1, 8'd9}, // R9 equal to turn-on
    '{16'd12501, 1'b1, 16'd11000, 1'b1, 1'b0, 1'b1, 8'd2}, // R2 low released, high in band
    '{16'd12000, 1'b1, 16'd11601, 1'b1, 1'b0, 1'b0, 8'd6}, // R6 high freed
    '{16'd11599, 1'b1, 16'd11601, 1'b1, 1'b0, 1'b0, 8'd3}, // R3 dip 1
    '{16'd11599, 1'b1, 16'd11601, 1'b1, 1'b0, 1'b0, 8'd3}, // R3 dip 2
    '{16'd11600, 1'b1, 16'd11601, 1'b1, 1'b0, 1'b0, 8'd9}, // R9 equal restarts count
    '{16'd11000, 1'b1, 16'd11601, 1'b1, 1'b0, 1'b0, 8'd4}, // R4 dip 1 after restart
    '{16'd11000, 1'b1, 16'd11601, 1'b1, 1'b0, 1'b0, 8'd3}, // dip 2
    '{16'd11000, 1'b0, 16'd11601, 1'b0, 1'b0, 1'b0, 8'd5}, // R5 invalid, no count
    '{16'd11000, 1'b1, 16'd11601, 1'b1, 1'b0, 1'b0, 8'd3}, // dip 3
    '{16'd11000, 1'b1, 16'd11601, 1'b1, 1'b1, 1'b0, 8'd3}, // dip 4 locks, R8 high free
    '{16'd12000, 1'b1, 16'd11601, 1'b1, 1'b1, 1'b0, 8'd4}, // R4 band keeps lock
    '{16'd13000, 1'b1, 16'd10699, 1'b1, 1'b0, 1'b0, 8'd8}, // R8 high dip 1
    '{16'd13000, 1'b1, 16'd10699, 1'b1, 1'b0, 1'b0, 8'd8}, // high dip 2
    '{16'd13000, 1'b1, 16'd10699, 1'b1, 1'b0, 1'b0, 8'd8}, // high dip 3
    '{16'd13000, 1'b1, 16'd10699, 1'b1, 1'b0, 1'b1, 8'd6}, // R6 high locks below 10700
    '{16'd0,     1'b0, 16'd20000, 1'b0, 1'b0, 1'b1, 8'd5}, // R5 invalid extremes
    '{16'd0,     1'b0, 16'd20000, 1'b0, 1'b0, 1'b1, 8'd5}  // R5 still held
  };

  task automatic check(input logic act, input logic exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0b exp=%0b", req, act, exp);
    end
  endtask

  task automatic stepMos(input logic [15:0] lo, input logic [15:0] hi);
    @(negedge clk);
    mLowMv = lo; mHighMv = hi; mLowValid = 1'b1; mHighValid = 1'b1;
    @(negedge clk);
    mLowValid = 1'b0; mHighValid = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(lowLockout, 1'b1, "R1 low in reset");
    check(highLockout, 1'b1, "R1 high in reset");
    rstN = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(lowLockout, 1'b1, "R1 low after reset");
    check(highLockout, 1'b1, "R1 high after reset");

    // Vector table: drive on falling edge, compare one rising edge later.
    for (int i = 0; i < NV; i++) begin
      lowMv = VECS[i].lo; lowValid = VECS[i].loV;
      highMv = VECS[i].hi; highValid = VECS[i].hiV;
      @(negedge clk);
      total++;
      if (lowLockout !== VECS[i].expLo || highLockout !== VECS[i].expHi) begin
        bad++;
        $display("FAIL R%0d row %0d act=%0b%0b exp=%0b%0b", VECS[i].req, i,
                 lowLockout, highLockout, VECS[i].expLo, VECS[i].expHi);
      end
    end
    lowValid = 1'b0; highValid = 1'b0;

    // R7: shared thresholds in the alternate mode.
    stepMos(16'd9100, 16'd9100);
    check(mLowLockout, 1'b1, "R7 low equal turn-on");
    check(mHighLockout, 1'b1, "R7 high equal turn-on");
    stepMos(16'd9101, 16'd9101);
    check(mLowLockout, 1'b0, "R7 low released");
    check(mHighLockout, 1'b0, "R7 high released");
    stepMos(16'd8300, 16'd8300);
    stepMos(16'd8300, 16'd8300);
    check(mLowLockout, 1'b0, "R7 low equal turn-off");
    stepMos(16'd8299, 16'd9000);
    check(mLowLockout, 1'b0, "R7 low one dip");
    stepMos(16'd8299, 16'd9000);
    check(mLowLockout, 1'b1, "R7 low locks");
    check(mHighLockout, 1'b0, "R7 high in band");

    // R1: reset in mid run forces both flags on.
    @(negedge clk);
    lowMv = 16'd13000; highMv = 16'd13000; lowValid = 1'b1; highValid = 1'b1;
    @(negedge clk);
    lowValid = 1'b0; highValid = 1'b0;
    check(lowLockout, 1'b0, "R2 low freed before reset");
    rstN = 1'b0;
    #1;
    check(lowLockout, 1'b1, "R1 low mid-run reset");
    check(highLockout, 1'b1, "R1 high mid-run reset");
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule